// File: doc/BRIEF.md
# Burst-of-two DDR SRAM controller

This block sits between a simple request port and an external synchronous SRAM. The SRAM has one address and control bus that carries at most one command per clock. Its data port is a single bidirectional double-data-rate port. Every access, read or write, moves a pair of words: one word on the rising half of the clock and one on the falling half. Inside the chip the two beats appear side by side as one vector per clock. Beat 0 (the rising-edge word) sits in the low half and beat 1 in the high half. The shared port is modelled as an output vector, an output enable and an input vector.

The host presents one request per cycle. Each request carries a valid flag, a write select, a burst address, two write beats and one byte enable per 9-bit lane per beat. The controller registers the request onto the memory command pins. Write data and byte enables follow one clock after the write command, which is the late-write timing the memory expects. For a read, the controller counts a fixed number of cycles and captures both beats, but only if the memory's echo strobe marks the data as present. A write is held off while a recent read may still own the bus, so the controller's drivers and the memory's drivers never overlap.

Top module: `burst2_sram_ctrl`

## Requirements
- R1: While rst_ni is low, mem_ld_o, mem_dq_oe_o and rsp_valid_o are 0, and mem_bwe_o and mem_dq_o are all zero.
- R2: A request accepted at a clock edge (req_valid_i and req_ready_o both high) appears in the next cycle as mem_ld_o=1, with mem_rw_o=1 for a read or 0 for a write, and mem_addr_o equal to the request address.
- R3: One cycle after a write command is on the pins, mem_dq_oe_o is 1 for exactly one cycle. In that cycle mem_dq_o carries the request's beats, beat 0 in bits [DATA_W-1:0], and mem_bwe_o carries its byte enables. Bit b*LANES+l of mem_bwe_o enables 9-bit lane l of beat b.
- R4: A read accepted at edge A raises rsp_valid_o for one cycle after edge A+RD_LAT+1. rsp_rdata_o then holds both beats in the same layout as the write data, and these are the latest data written to that address.
- R5: A write request is held off (req_ready_o=0) while a read was accepted within the previous RD_LAT-1 edges. With RD_LAT=2 this inserts exactly one idle cycle. mem_dq_oe_o is never high in a cycle in which the memory drives read data.
- R6: In a cycle with no accepted request, the next cycle has mem_ld_o=0. If no write was accepted, then one cycle later mem_dq_oe_o=0, mem_bwe_o=0 and mem_dq_o=0, whatever req_wdata_i and req_be_i held.
- R7: Reads are never held off. A read directly after a write, or after another read, is accepted in the next cycle, giving one command per clock.
- R8: A write changes only the 9-bit lanes whose byte-enable bit is 1. A later read returns the old contents in the other lanes.
- R9: If mem_echo_i is low in the cycle the read data is due, rsp_valid_o stays 0 for that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Burst address |
| req_wdata_i | input | 2*DATA_W | Write beats, beat 0 low |
| req_be_i | input | 2*LANES | Lane enables per beat |
| rsp_valid_o | output | 1 | Read beats valid |
| rsp_rdata_o | output | 2*DATA_W | Read beats, beat 0 low |
| mem_ld_o | output | 1 | Command load strobe |
| mem_rw_o | output | 1 | 1 = read, 0 = write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_bwe_o | output | 2*LANES | Lane write enables, with data |
| mem_dq_o | output | 2*DATA_W | Data driven to memory |
| mem_dq_oe_o | output | 1 | Drive enable for shared data port |
| mem_dq_i | input | 2*DATA_W | Data returned from memory |
| mem_echo_i | input | 1 | Echo strobe qualifying returned data |

## Verification
The bench first runs streams of back-to-back full-lane writes, then back-to-back reads. These show whether command timing and beat ordering hold at one command per clock. A write issued straight after a read tests whether exactly one idle cycle is inserted. A read straight after a write to the same address tests that reads do not stall and that the late-write data is visible. Partial lane enables separate a masked write from a full one. Idle cycles with junk write data and lane enables show whether anything leaks onto the port. A read with the echo strobe removed separates capture that is qualified by the echo from capture based on latency alone.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
  localparam int LANE_W = 9;
  typedef enum logic {RW_WRITE = 1'b0, RW_READ = 1'b1} rw_e;
endpackage

// File: rtl/b2s_cmd_issue.sv
module b2s_cmd_issue
  import b2s_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ready_o,
  output logic              fire_wr_o,
  output logic              fire_rd_o,
  output logic              ld_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HOLD_N = (RD_LAT > 1) ? RD_LAT - 1 : 1;

  logic [HOLD_N-1:0] rd_hist;
  logic rd_block, fire;
  rw_e  rw_d;

  // a write whose late data would land on a pending read window waits
  assign rd_block  = (RD_LAT > 1) && (|rd_hist);
  assign ready_o   = !(we_i && rd_block);
  assign fire      = valid_i && ready_o;
  assign fire_wr_o = fire && we_i;
  assign fire_rd_o = fire && !we_i;
  assign rw_d      = we_i ? RW_WRITE : RW_READ;

  generate
    if (HOLD_N == 1) begin : g_hist_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rd_hist <= '0;
        else         rd_hist <= fire_rd_o;
    end else begin : g_hist_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) rd_hist <= '0;
        else         rd_hist <= {rd_hist[HOLD_N-2:0], fire_rd_o};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_o   <= 1'b0;
      rw_o   <= RW_READ;
      addr_o <= '0;
    end else begin
      ld_o <= fire;
      if (fire) begin
        rw_o   <= rw_d;
        addr_o <= addr_i;
      end else begin
        rw_o <= RW_READ;
      end
    end
  end
endmodule

// File: rtl/b2s_wr_path.sv
module b2s_wr_path #(
  parameter int DATA_W = 18,
  parameter int LANES  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_wr_i,
  input  logic [2*DATA_W-1:0] wdata_i,
  input  logic [2*LANES-1:0]  be_i,
  output logic                oe_o,
  output logic [2*DATA_W-1:0] dq_o,
  output logic [2*LANES-1:0]  bwe_o
);
  logic                s1_vld;
  logic [2*DATA_W-1:0] s1_data;
  logic [2*LANES-1:0]  s1_be;

  // stage 1 aligns with the command, stage 2 drives the port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_data <= '0;
      s1_be   <= '0;
      oe_o    <= 1'b0;
      dq_o    <= '0;
      bwe_o   <= '0;
    end else begin
      s1_vld  <= fire_wr_i;
      s1_data <= fire_wr_i ? wdata_i : '0;
      s1_be   <= fire_wr_i ? be_i : '0;
      oe_o    <= s1_vld;
      dq_o    <= s1_vld ? s1_data : '0;
      bwe_o   <= s1_vld ? s1_be : '0;
    end
  end
endmodule

// File: rtl/b2s_rd_capture.sv
module b2s_rd_capture #(
  parameter int DATA_W = 18,
  parameter int RD_LAT = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fire_rd_i,
  input  logic [2*DATA_W-1:0] dq_i,
  input  logic                echo_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_rdata_o
);
  logic [RD_LAT:0] pend;
  logic            take;

  // pend[k] is set k edges after acceptance; tap RD_LAT is the bus window
  assign take = pend[RD_LAT] && echo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      pend        <= {pend[RD_LAT-1:0], fire_rd_i};
      rsp_valid_o <= take;
      if (take) rsp_rdata_o <= dq_i;
    end
  end
endmodule

// File: rtl/burst2_sram_ctrl.sv
module burst2_sram_ctrl
  import b2s_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 2,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [2*DATA_W-1:0] req_wdata_i,
  input  logic [2*LANES-1:0]  req_be_i,
  output logic                rsp_valid_o,
  output logic [2*DATA_W-1:0] rsp_rdata_o,
  output logic                mem_ld_o,
  output logic                mem_rw_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*LANES-1:0]  mem_bwe_o,
  output logic [2*DATA_W-1:0] mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [2*DATA_W-1:0] mem_dq_i,
  input  logic                mem_echo_i
);
  logic fire_wr, fire_rd;

  b2s_cmd_issue #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_cmd (
    .clk_i, .rst_ni,
    .valid_i   (req_valid_i),
    .we_i      (req_we_i),
    .addr_i    (req_addr_i),
    .ready_o   (req_ready_o),
    .fire_wr_o (fire_wr),
    .fire_rd_o (fire_rd),
    .ld_o      (mem_ld_o),
    .rw_o      (mem_rw_o),
    .addr_o    (mem_addr_o)
  );

  b2s_wr_path #(.DATA_W(DATA_W), .LANES(LANES)) u_wr (
    .clk_i, .rst_ni,
    .fire_wr_i (fire_wr),
    .wdata_i   (req_wdata_i),
    .be_i      (req_be_i),
    .oe_o      (mem_dq_oe_o),
    .dq_o      (mem_dq_o),
    .bwe_o     (mem_bwe_o)
  );

  b2s_rd_capture #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_rd (
    .clk_i, .rst_ni,
    .fire_rd_i   (fire_rd),
    .dq_i        (mem_dq_i),
    .echo_i      (mem_echo_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/b2s_ctrl_chk.sv
module b2s_ctrl_chk #(
  parameter int BE_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_we_i,
  input logic            req_ready_o,
  input logic            mem_ld_o,
  input logic            mem_rw_o,
  input logic            mem_dq_oe_o,
  input logic [BE_W-1:0] mem_bwe_o,
  input logic            mem_echo_i,
  input logic            rsp_valid_o
);
  p_cmd_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_ld_o);

  p_idle_no_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !mem_ld_o);

  p_wdata_follows_wcmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ld_o && !mem_rw_o) |=> mem_dq_oe_o);

  p_no_drive_without_wcmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_ld_o && !mem_rw_o) |=> !mem_dq_oe_o);

  p_bwe_only_when_driving_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_dq_oe_o |-> (mem_bwe_o == '0));

  p_turnaround_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ld_o && mem_rw_o) |=> !(mem_ld_o && !mem_rw_o));

  p_read_never_stalls_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |-> req_ready_o);

  p_rsp_needs_echo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(mem_echo_i));
endmodule

bind burst2_sram_ctrl b2s_ctrl_chk #(.BE_W(2*LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_ready_o (req_ready_o),
  .mem_ld_o    (mem_ld_o),
  .mem_rw_o    (mem_rw_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_bwe_o   (mem_bwe_o),
  .mem_echo_i  (mem_echo_i),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/b2s_sram_model.sv
module b2s_sram_model #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 20,
  parameter int RD_LAT = 2,
  parameter int IDX_W  = 4,
  localparam int LANES = DATA_W / 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic                rw_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*LANES-1:0]  bwe_i,
  input  logic [2*DATA_W-1:0] dq_i,
  input  logic                oe_i,
  input  logic                echo_en_i,
  output logic [2*DATA_W-1:0] dq_o,
  output logic                drv_o,
  output logic                echo_o
);
  logic [2*DATA_W-1:0] mem [2**IDX_W];
  logic [RD_LAT-1:0]   rv;
  logic [IDX_W-1:0]    ra [RD_LAT];
  logic                wpend;
  logic [IDX_W-1:0]    wa;

  assign drv_o  = rv[RD_LAT-1];
  assign echo_o = drv_o && echo_en_i;
  assign dq_o   = drv_o ? mem[ra[RD_LAT-1]] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv    <= '0;
      wpend <= 1'b0;
      wa    <= '0;
      for (int i = 0; i < RD_LAT; i++) ra[i] <= '0;
    end else begin
      rv[0] <= ld_i && rw_i;
      ra[0] <= addr_i[IDX_W-1:0];
      for (int i = 1; i < RD_LAT; i++) begin
        rv[i] <= rv[i-1];
        ra[i] <= ra[i-1];
      end
      wpend <= ld_i && !rw_i;
      wa    <= addr_i[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk_i)
    if (wpend && oe_i)
      for (int b = 0; b < 2*LANES; b++)
        if (bwe_i[b]) mem[wa][b*9 +: 9] <= dq_i[b*9 +: 9];
endmodule

// File: tb/sim_burst2_sram_ctrl.sv
`timescale 1ns/1ps
module sim_burst2_sram_ctrl;
  localparam int DW = 18, AW = 20, RL = 2, L = DW / 9;
  localparam int VW = 2 * DW, BW = 2 * L;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, req_we = 0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [VW-1:0] req_wdata = '0, rsp_rdata, mem_dq_o, mem_dq_i, mdl_dq;
  logic [BW-1:0] req_be = '0, mem_bwe;
  logic rsp_valid, mem_ld, mem_rw, mem_oe, mem_echo, mdl_drv;
  logic echo_en = 1;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  burst2_sram_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(RL)) u0 (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_ld_o(mem_ld), .mem_rw_o(mem_rw), .mem_addr_o(mem_addr),
    .mem_bwe_o(mem_bwe), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_oe),
    .mem_dq_i(mem_dq_i), .mem_echo_i(mem_echo));

  b2s_sram_model #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(RL)) u_mdl (
    .clk_i(clk), .rst_ni, .ld_i(mem_ld), .rw_i(mem_rw), .addr_i(mem_addr),
    .bwe_i(mem_bwe), .dq_i(mem_dq_o), .oe_i(mem_oe), .echo_en_i(echo_en),
    .dq_o(mdl_dq), .drv_o(mdl_drv), .echo_o(mem_echo));

  assign mem_dq_i = mdl_drv ? mdl_dq : '0;

  int checks = 0, fails = 0, cyc = 0, stalls = 0;
  bit done = 0;
  logic [VW-1:0]   ref_mem [int];
  logic [AW:0]     exp_cmd [int];
  logic [VW+BW-1:0] exp_wr [int];
  logic [VW:0]     exp_rsp [int];

  task automatic chk(input string r, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  function automatic logic [VW-1:0] pat(input int k);
    return VW'(36'(k) * 36'h09E3779B1 ^ 36'h5A5A5A5A5);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle comparison against the behavioural expectations
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (exp_cmd.exists(cyc)) begin
        chk("R2 ld", mem_ld === 1'b1, 64'(mem_ld), 1);
        chk("R2 rw/addr", {mem_rw, mem_addr} === exp_cmd[cyc], 64'({mem_rw, mem_addr}), 64'(exp_cmd[cyc]));
      end else
        chk("R6 ld idle", mem_ld === 1'b0, 64'(mem_ld), 0);
      if (exp_wr.exists(cyc)) begin
        chk("R3 oe", mem_oe === 1'b1, 64'(mem_oe), 1);
        chk("R3 dq/bwe", {mem_bwe, mem_dq_o} === exp_wr[cyc], 64'({mem_bwe, mem_dq_o}), 64'(exp_wr[cyc]));
      end else
        chk("R6 port idle", {mem_oe, mem_bwe, mem_dq_o} === '0, 64'({mem_oe, mem_bwe, mem_dq_o}), 0);
      chk("R5 no contention", !(mem_oe && mdl_drv), 64'({mem_oe, mdl_drv}), 0);
      if (exp_rsp.exists(cyc) && exp_rsp[cyc][VW]) begin
        chk("R4 rsp valid", rsp_valid === 1'b1, 64'(rsp_valid), 1);
        chk("R4/R8 rsp data", rsp_rdata === exp_rsp[cyc][VW-1:0], 64'(rsp_rdata), 64'(exp_rsp[cyc][VW-1:0]));
      end else if (exp_rsp.exists(cyc))
        chk("R9 no rsp without echo", rsp_valid === 1'b0, 64'(rsp_valid), 0);
      else
        chk("R4 rsp idle", rsp_valid === 1'b0, 64'(rsp_valid), 0);
    end
  end

  task automatic req(input logic we, input int a, input logic [VW-1:0] d, input logic [BW-1:0] be);
    int acc;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = AW'(a); req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk); #1;
    end
    acc = cyc + 1;
    exp_cmd[acc] = {~we, AW'(a)};
    if (we) begin
      exp_wr[acc+1] = {be, d};
      if (!ref_mem.exists(a)) ref_mem[a] = '0;
      for (int b = 0; b < BW; b++)
        if (be[b]) ref_mem[a][b*9 +: 9] = d[b*9 +: 9];
    end else
      exp_rsp[acc+RL+1] = {echo_en, ref_mem[a]};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; req_we = 1; req_wdata = pat(900 + i); req_be = '1;
    end
  endtask

  initial begin
    int s0;
    #2;
    chk("R1 reset", {mem_ld, mem_oe, rsp_valid, mem_bwe, mem_dq_o} === '0,
        64'({mem_ld, mem_oe, rsp_valid, mem_bwe, mem_dq_o}), 0);
    repeat (3) @(negedge clk);
    chk("R1 reset held", {mem_ld, mem_oe, rsp_valid} === 3'b0, 64'({mem_ld, mem_oe, rsp_valid}), 0);
    rst_ni = 1;
    idle(2);
    // full-lane write stream, then read stream
    for (int i = 0; i < 8; i++) req(1, i, pat(i), '1);
    for (int i = 0; i < 8; i++) req(0, i, pat(50 + i), '0);
    idle(5);
    // read directly followed by write: one idle slot
    s0 = stalls;
    req(0, 3, '0, '0);
    req(1, 9, pat(20), '1);
    chk("R5 single stall", stalls - s0 == 1, 64'(stalls - s0), 1);
    idle(4);
    // write then read same address, no stall
    s0 = stalls;
    req(1, 10, pat(21), '1);
    req(0, 10, '0, '0);
    req(0, 9, '0, '0);
    chk("R7 no read stall", stalls == s0, 64'(stalls - s0), 0);
    idle(5);
    // partial lanes: beat0 lane1 and beat1 lane0 only
    req(1, 4, pat(77), BW'(4'b0110));
    req(0, 4, '0, '0);
    req(1, 5, pat(78), BW'(4'b1001));
    idle(1);
    req(0, 5, '0, '0);
    idle(6);
    // read with echo removed
    echo_en = 0;
    req(0, 2, '0, '0);
    idle(6);
    echo_en = 1;
    req(0, 2, '0, '0);
    idle(8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule